// File: doc/BRIEF.md
# Tiered System Reset Sequencer

This block gathers every reset request in the chip and turns each one into one of three reset flows. The requests come from a power-on input, a bidirectional open-drain hard-reset pin, a watchdog expiry, a bus-monitor timeout and a test-port isolation command. The three flows are power-on, hard and soft. Each flow asserts its own group of domain resets: configuration capture, the PLL/DLL, the hard-reset pin driver, the timer registers, the clock-control logic, the core and the peripherals. A five-bit cause register keeps a record of the sources behind the latest reset so that software can read them after boot.

The tiers are strictly ranked: power-on, then hard, then soft. A request of a higher tier that arrives during a lower flow promotes the controller into the higher flow at once. A request of a lower tier never interrupts a higher flow. When the last request of the active tier goes away, every domain reset of that flow stays asserted for a fixed hold window and then all of them release on the same cycle.

The block has no streaming data path. Every pin is a plain level control or status signal, so the block needs no valid/ready handshake and applies no back-pressure.

Top module: `reset_sequencer`

## Requirements
- R1: A power-on request counts only after the synchronised power-on input (active low) has been low for at least 16 consecutive clock samples. A low pulse of 15 samples or fewer changes no output and leaves the cause register as it was.
- R2: After reset, all domain resets are deasserted, the cause register is zero and the latched configuration is zero. While the power-on flow is active, all seven domain outputs are high, including the PLL reset, configuration capture and the pin driver.
- R3: The configuration inputs are copied into `cfg_latched_o` only while the power-on flow is active. The value seen on its last cycle is kept, and any other flow leaves it unchanged.
- R4: A low level on the hard-reset pin that the block is not driving itself starts the hard flow. So does an enabled watchdog expiry, and so does an enabled bus-monitor expiry.
- R5: The hard flow asserts the pin driver, timer, clock-control, core and peripheral resets. It does not assert the PLL reset or configuration capture.
- R6: The pin is open-drain. `hrst_pin_oe` is high only in the hard and power-on flows. The block ignores the pin level while it drives the pin and for a short settle window after it releases it, so the block never re-triggers itself.
- R7: While the test-port isolation request is high, the soft flow runs. It asserts the timer, clock-control, core and peripheral resets and nothing else. The pin driver stays off.
- R8: The cause register bits are: bit 0 power-on, bit 1 hard-reset pin, bit 2 watchdog, bit 3 bus monitor, bit 4 test port. Entering the power-on flow clears the register to the power-on bit alone.
- R9: Power-on outranks hard, and hard outranks soft. A higher request during a lower flow switches to the higher flow. A lower request during a higher flow is ignored until that flow ends, and the lower request then starts its own flow if it is still present.
- R10: Domain resets stay asserted for 32 cycles after the last cycle on which a request of the active tier is seen. They then release together and the controller returns to idle.
- R11: Entering the hard or soft flow overwrites the cause register with the causes seen on that cycle. Two hard sources on the same cycle set both of their bits.
- R12: The watchdog and bus-monitor inputs act only on a rising edge, and only while their own enable is high. A level held high produces exactly one flow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| ctl_arst_n | input | 1 | Asynchronous clear of the controller state from power detection, active low |
| por_req_n | input | 1 | Power-on reset request, active low, asynchronous |
| hrst_pin_i | input | 1 | Sensed level of the open-drain hard-reset pin, active low |
| hrst_pin_oe | output | 1 | Pull the hard-reset pin low when high |
| wdog_expire | input | 1 | Watchdog count reached zero |
| wdog_en | input | 1 | Watchdog reset enable |
| bmon_expire | input | 1 | Bus-monitor count reached zero |
| bmon_en | input | 1 | Bus-monitor reset enable |
| tap_isolate | input | 1 | Test port is running a boundary/clamp/high-impedance command |
| cfg_pins_i | input | CFG_W | System configuration inputs |
| cfg_latched_o | output | CFG_W | Configuration captured during the power-on flow |
| rst_pll_o | output | 1 | PLL/DLL reset |
| rst_cfg_o | output | 1 | Configuration capture window |
| rst_tmr_o | output | 1 | Watchdog/monitor timer register reset |
| rst_clkctl_o | output | 1 | Clock-control logic reset |
| rst_core_o | output | 1 | Core reset |
| rst_periph_o | output | 1 | Peripheral reset |
| cause_o | output | 5 | Latest reset causes, bit map as in R8 |

## Verification
Two pairs of functions can land on the same clock edge, and both are forced deliberately. First, the watchdog and bus-monitor edges are driven on the same cycle; the cause register must then show both bits. Second, a test-port request and a watchdog edge are raised together. The hard flow must win that cycle, and the soft flow must start only after the hard hold window ends, while the test-port request is still high. Power-on during a hard flow, and a bus-monitor edge during power-on, are also checked through the domain outputs and the cause register to confirm the tier ranking.

// File: rtl/rstc_pkg.sv
`timescale 1ns/1ps
package rstc_pkg;

  typedef enum logic [1:0] {
    FLOW_IDLE = 2'd0,
    FLOW_SOFT = 2'd1,
    FLOW_HARD = 2'd2,
    FLOW_POR  = 2'd3
  } flow_e;

  localparam int SRC_N   = 5;
  localparam int SB_POR  = 0;
  localparam int SB_PIN  = 1;
  localparam int SB_WDOG = 2;
  localparam int SB_BMON = 3;
  localparam int SB_TAP  = 4;

  localparam int HARD_N  = 3;   // hard sources: pin, watchdog, bus monitor
  localparam int HS_PIN  = 0;
  localparam int HS_WDOG = 1;
  localparam int HS_BMON = 2;

  typedef struct packed {
    logic pll;
    logic cfg;
    logic pin;
    logic tmr;
    logic clk;
    logic core;
    logic periph;
  } dom_t;

endpackage

// File: rtl/rstc_sync.sv
`timescale 1ns/1ps
module rstc_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) st[s] <= {W{RST_VAL}};
      else if (s == 0) st[s] <= d;
      else st[s] <= st[(s == 0) ? 0 : s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/rstc_por_filter.sv
`timescale 1ns/1ps
module rstc_por_filter #(
  parameter int MIN_CYC = 16
) (
  input  logic clk,
  input  logic arst_n,
  input  logic por_low,
  output logic por_req
);
  localparam int CW = $clog2(MIN_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt     <= '0;
      por_req <= 1'b0;
    end else if (!por_low) begin
      cnt     <= '0;
      por_req <= 1'b0;
    end else begin
      if (cnt != CW'(MIN_CYC)) cnt <= cnt + 1'b1;
      if (cnt == CW'(MIN_CYC - 1)) por_req <= 1'b1;
    end
  end

  AST_POR_MIN_WIDTH: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(por_req) |-> (cnt == CW'(MIN_CYC))); // R1
endmodule

// File: rtl/rstc_src_detect.sv
`timescale 1ns/1ps
module rstc_src_detect
  import rstc_pkg::*;
#(
  parameter int SETTLE = 4
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              pin_low,
  input  logic              pin_oe,
  input  logic              wdog_expire,
  input  logic              wdog_en,
  input  logic              bmon_expire,
  input  logic              bmon_en,
  input  logic              tap_req,
  output logic [HARD_N-1:0] hard_src,
  output logic              soft_req
);
  localparam int SW = $clog2(SETTLE + 1);

  logic [SW-1:0] settle;
  logic          wdog_q, bmon_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      settle   <= '0;
      wdog_q   <= 1'b0;
      bmon_q   <= 1'b0;
      hard_src <= '0;
      soft_req <= 1'b0;
    end else begin
      wdog_q <= wdog_expire;
      bmon_q <= bmon_expire;
      if (pin_oe)              settle <= SW'(SETTLE);
      else if (settle != '0)   settle <= settle - 1'b1;
      hard_src[HS_PIN]  <= pin_low && !pin_oe && (settle == '0);
      hard_src[HS_WDOG] <= wdog_expire && !wdog_q && wdog_en;
      hard_src[HS_BMON] <= bmon_expire && !bmon_q && bmon_en;
      soft_req          <= tap_req;
    end
  end

  AST_WDOG_SINGLE: assert property (@(posedge clk) disable iff (!arst_n)
    hard_src[HS_WDOG] |=> !hard_src[HS_WDOG]); // R12
  AST_BMON_SINGLE: assert property (@(posedge clk) disable iff (!arst_n)
    hard_src[HS_BMON] |=> !hard_src[HS_BMON]); // R12
  AST_PIN_SELF_MASK: assert property (@(posedge clk) disable iff (!arst_n)
    pin_oe |=> !hard_src[HS_PIN]); // R6
endmodule

// File: rtl/rstc_flow_fsm.sv
`timescale 1ns/1ps
module rstc_flow_fsm
  import rstc_pkg::*;
#(
  parameter int HOLD_CYC = 32
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              por_req,
  input  logic [HARD_N-1:0] hard_src,
  input  logic              soft_req,
  output flow_e             flow,
  output logic [SRC_N-1:0]  cause
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  flow_e            req_flow;
  logic [SRC_N-1:0] req_cause;
  logic [HW-1:0]    hold;

  always_comb begin
    req_cause = '0;
    req_flow  = FLOW_IDLE;
    if (por_req) begin
      req_flow          = FLOW_POR;
      req_cause[SB_POR] = 1'b1;
    end else if (|hard_src) begin
      req_flow           = FLOW_HARD;
      req_cause[SB_PIN]  = hard_src[HS_PIN];
      req_cause[SB_WDOG] = hard_src[HS_WDOG];
      req_cause[SB_BMON] = hard_src[HS_BMON];
    end else if (soft_req) begin
      req_flow          = FLOW_SOFT;
      req_cause[SB_TAP] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      flow  <= FLOW_IDLE;
      hold  <= '0;
      cause <= '0;
    end else if (req_flow > flow) begin
      flow  <= req_flow;
      hold  <= HW'(HOLD_CYC);
      cause <= req_cause;
    end else if (req_flow == flow && flow != FLOW_IDLE) begin
      hold  <= HW'(HOLD_CYC);
      cause <= cause | req_cause;
    end else if (flow != FLOW_IDLE) begin
      if (hold <= HW'(1)) flow <= FLOW_IDLE;
      else                hold <= hold - 1'b1;
    end
  end

  AST_POR_NO_DOWNGRADE: assert property (@(posedge clk) disable iff (!arst_n)
    (flow == FLOW_POR) |=> (flow == FLOW_POR || flow == FLOW_IDLE)); // R9
  AST_HARD_NOT_SOFT: assert property (@(posedge clk) disable iff (!arst_n)
    (flow == FLOW_HARD) |=> (flow != FLOW_SOFT)); // R9
  AST_POR_CAUSE_ONLY: assert property (@(posedge clk) disable iff (!arst_n)
    (flow == FLOW_POR) |-> (cause == SRC_N'(1) << SB_POR)); // R8
endmodule

// File: rtl/rstc_domain_map.sv
`timescale 1ns/1ps
module rstc_domain_map
  import rstc_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             arst_n,
  input  flow_e            flow,
  input  logic [CFG_W-1:0] cfg_pins,
  output dom_t             dom,
  output logic [CFG_W-1:0] cfg_latched
);
  always_comb begin
    dom = '0;
    unique case (flow)
      FLOW_POR:  dom = '1;
      FLOW_HARD: begin
        dom.pin    = 1'b1;
        dom.tmr    = 1'b1;
        dom.clk    = 1'b1;
        dom.core   = 1'b1;
        dom.periph = 1'b1;
      end
      FLOW_SOFT: begin
        dom.tmr    = 1'b1;
        dom.clk    = 1'b1;
        dom.core   = 1'b1;
        dom.periph = 1'b1;
      end
      default: dom = '0;
    endcase
  end

  for (genvar b = 0; b < CFG_W; b++) begin : g_cfg
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)      cfg_latched[b] <= 1'b0;
      else if (dom.cfg) cfg_latched[b] <= cfg_pins[b];
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!arst_n)
    !dom.cfg |=> $stable(cfg_latched)); // R3
endmodule

// File: rtl/reset_sequencer.sv
`timescale 1ns/1ps
module reset_sequencer
  import rstc_pkg::*;
#(
  parameter int CFG_W    = 8,
  parameter int POR_MIN  = 16,
  parameter int HOLD_CYC = 32,
  parameter int SETTLE   = 4,
  parameter int SYNC_N   = 2
) (
  input  logic             clk_ref,
  input  logic             ctl_arst_n,
  input  logic             por_req_n,
  input  logic             hrst_pin_i,
  output logic             hrst_pin_oe,
  input  logic             wdog_expire,
  input  logic             wdog_en,
  input  logic             bmon_expire,
  input  logic             bmon_en,
  input  logic             tap_isolate,
  input  logic [CFG_W-1:0] cfg_pins_i,
  output logic [CFG_W-1:0] cfg_latched_o,
  output logic             rst_pll_o,
  output logic             rst_cfg_o,
  output logic             rst_tmr_o,
  output logic             rst_clkctl_o,
  output logic             rst_core_o,
  output logic             rst_periph_o,
  output logic [4:0]       cause_o
);
  logic [1:0]        pins_s;
  logic              por_req;
  logic [HARD_N-1:0] hard_src;
  logic              soft_req;
  flow_e             flow;
  dom_t              dom;
  logic [SRC_N-1:0]  cause;

  rstc_sync #(.W(2), .STAGES(SYNC_N), .RST_VAL(1'b1)) i_sync (
    .clk(clk_ref), .arst_n(ctl_arst_n),
    .d({hrst_pin_i, por_req_n}), .q(pins_s));

  rstc_por_filter #(.MIN_CYC(POR_MIN)) i_por (
    .clk(clk_ref), .arst_n(ctl_arst_n),
    .por_low(!pins_s[0]), .por_req(por_req));

  rstc_src_detect #(.SETTLE(SETTLE)) i_det (
    .clk(clk_ref), .arst_n(ctl_arst_n),
    .pin_low(!pins_s[1]), .pin_oe(dom.pin),
    .wdog_expire(wdog_expire), .wdog_en(wdog_en),
    .bmon_expire(bmon_expire), .bmon_en(bmon_en),
    .tap_req(tap_isolate), .hard_src(hard_src), .soft_req(soft_req));

  rstc_flow_fsm #(.HOLD_CYC(HOLD_CYC)) i_fsm (
    .clk(clk_ref), .arst_n(ctl_arst_n),
    .por_req(por_req), .hard_src(hard_src), .soft_req(soft_req),
    .flow(flow), .cause(cause));

  rstc_domain_map #(.CFG_W(CFG_W)) i_map (
    .clk(clk_ref), .arst_n(ctl_arst_n), .flow(flow),
    .cfg_pins(cfg_pins_i), .dom(dom), .cfg_latched(cfg_latched_o));

  assign hrst_pin_oe  = dom.pin;
  assign rst_pll_o    = dom.pll;
  assign rst_cfg_o    = dom.cfg;
  assign rst_tmr_o    = dom.tmr;
  assign rst_clkctl_o = dom.clk;
  assign rst_core_o   = dom.core;
  assign rst_periph_o = dom.periph;
  assign cause_o      = cause;

  AST_PLL_NEEDS_POR_CAUSE: assert property (@(posedge clk_ref) disable iff (!ctl_arst_n)
    rst_pll_o |-> cause_o[SB_POR]); // R2
  AST_PIN_WITH_CORE: assert property (@(posedge clk_ref) disable iff (!ctl_arst_n)
    hrst_pin_oe |-> (rst_core_o && rst_periph_o && rst_tmr_o)); // R5
  AST_CORE_HAS_CAUSE: assert property (@(posedge clk_ref) disable iff (!ctl_arst_n)
    rst_core_o |-> (cause_o != '0)); // R11
endmodule

// File: tb/test_reset_sequencer.sv
`timescale 1ns/1ps
module test_reset_sequencer;
  logic       clk_ref = 1'b0;
  logic       ctl_arst_n = 1'b0;
  logic       por_req_n = 1'b1;
  logic       ext_pin_low = 1'b0;
  logic       hrst_pin_i;
  logic       hrst_pin_oe;
  logic       wdog_expire = 1'b0, wdog_en = 1'b0;
  logic       bmon_expire = 1'b0, bmon_en = 1'b0;
  logic       tap_isolate = 1'b0;
  logic [7:0] cfg_pins_i = 8'h00;
  logic [7:0] cfg_latched_o;
  logic       rst_pll_o, rst_cfg_o, rst_tmr_o, rst_clkctl_o, rst_core_o, rst_periph_o;
  logic [4:0] cause_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk_ref = ~clk_ref;

  assign hrst_pin_i = !(hrst_pin_oe || ext_pin_low);

  reset_sequencer i_reset_sequencer (
    .clk_ref(clk_ref), .ctl_arst_n(ctl_arst_n), .por_req_n(por_req_n),
    .hrst_pin_i(hrst_pin_i), .hrst_pin_oe(hrst_pin_oe),
    .wdog_expire(wdog_expire), .wdog_en(wdog_en),
    .bmon_expire(bmon_expire), .bmon_en(bmon_en),
    .tap_isolate(tap_isolate), .cfg_pins_i(cfg_pins_i),
    .cfg_latched_o(cfg_latched_o), .rst_pll_o(rst_pll_o), .rst_cfg_o(rst_cfg_o),
    .rst_tmr_o(rst_tmr_o), .rst_clkctl_o(rst_clkctl_o), .rst_core_o(rst_core_o),
    .rst_periph_o(rst_periph_o), .cause_o(cause_o));

  wire [6:0] dom_v = {rst_pll_o, rst_cfg_o, hrst_pin_oe, rst_tmr_o,
                      rst_clkctl_o, rst_core_o, rst_periph_o};

  // flow: 3 power-on, 2 hard, 1 soft, 0 idle
  function automatic logic [6:0] exp_dom(int fl);
    case (fl)
      3:       return 7'b1111111;
      2:       return 7'b0011111;
      1:       return 7'b0001111;
      default: return 7'b0000000;
    endcase
  endfunction

  // src: 0 pin, 1 watchdog, 2 bus monitor, 3 test port
  function automatic logic [4:0] cause_bit(int src);
    case (src)
      0:       return 5'b00010;
      1:       return 5'b00100;
      2:       return 5'b01000;
      default: return 5'b10000;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk_ref);
  endtask

  task automatic run_src(int src, bit en);
    logic [4:0] prev = cause_o;
    bit fires;
    case (src)
      0: begin ext_pin_low = 1'b1; cyc(3); ext_pin_low = 1'b0; end
      1: begin wdog_en = en; wdog_expire = 1'b1; cyc(2); wdog_expire = 1'b0; end
      2: begin bmon_en = en; bmon_expire = 1'b1; cyc(2); bmon_expire = 1'b0; end
      default: begin tap_isolate = 1'b1; cyc(4); tap_isolate = 1'b0; end
    endcase
    fires = (src == 0 || src == 3) ? 1'b1 : en;
    cyc(6);
    chk("R4_R7_R12 domains after source", dom_v,
        fires ? exp_dom(src == 3 ? 1 : 2) : 7'd0);
    chk("R11_R12 cause after source", cause_o, fires ? cause_bit(src) : prev);
    cyc(18);
    chk("R10 still held", dom_v, fires ? exp_dom(src == 3 ? 1 : 2) : 7'd0);
    cyc(30);
    chk("R10_R6 released and no self retrigger", dom_v, 7'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_ref);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    cyc(4);
    ctl_arst_n = 1'b1;
    cyc(3);
    chk("R2 reset domains", dom_v, 7'd0);
    chk("R2 reset cause", cause_o, 5'd0);
    chk("R2 reset cfg", cfg_latched_o, 8'd0);

    // R1: 15-cycle pulse ignored
    cfg_pins_i = 8'h5A;
    por_req_n = 1'b0; cyc(15); por_req_n = 1'b1; cyc(10);
    chk("R1 short pulse domains", dom_v, 7'd0);
    chk("R1 short pulse cause", cause_o, 5'd0);
    chk("R1 short pulse cfg", cfg_latched_o, 8'd0);

    // R1: 16-cycle pulse accepted
    por_req_n = 1'b0; cyc(16); por_req_n = 1'b1; cyc(5);
    chk("R1_R2 power-on domains", dom_v, exp_dom(3));
    chk("R8 power-on cause", cause_o, 5'b00001);
    cyc(20);
    chk("R10 power-on held", dom_v, exp_dom(3));
    cyc(25);
    chk("R10 power-on released", dom_v, 7'd0);
    chk("R3 cfg captured", cfg_latched_o, 8'h5A);

    // random single-source trials
    for (int i = 0; i < 30; i++) begin
      int src = int'($urandom_range(3, 0));
      bit en  = 1'($urandom_range(1, 0));
      run_src(src, en);
    end

    // R12: held level gives one flow
    wdog_en = 1'b1; wdog_expire = 1'b1; cyc(8);
    chk("R12 held level starts hard", dom_v, exp_dom(2));
    cyc(52);
    chk("R12 held level single flow", dom_v, 7'd0);
    wdog_expire = 1'b0; cyc(5);

    // R11: two hard sources on the same cycle
    bmon_en = 1'b1;
    wdog_expire = 1'b1; bmon_expire = 1'b1; cyc(2);
    wdog_expire = 1'b0; bmon_expire = 1'b0; cyc(6);
    chk("R11 both causes", cause_o, 5'b01100);
    chk("R5 hard domains", dom_v, exp_dom(2));
    cyc(50);

    // R9: soft and hard on the same cycle
    tap_isolate = 1'b1; wdog_expire = 1'b1; cyc(2); wdog_expire = 1'b0; cyc(6);
    chk("R9 hard beats soft", dom_v, exp_dom(2));
    chk("R11 cause hard only", cause_o, 5'b00100);
    cyc(45);
    chk("R9 soft after hard", dom_v, exp_dom(1));
    chk("R7 cause soft", cause_o, 5'b10000);
    wdog_expire = 1'b1; cyc(2); wdog_expire = 1'b0; cyc(6);
    chk("R9 hard promotes soft", dom_v, exp_dom(2));
    chk("R11 overwrite cause", cause_o, 5'b00100);
    cfg_pins_i = 8'h33;
    por_req_n = 1'b0; cyc(24);
    chk("R9 power-on promotes hard", dom_v, exp_dom(3));
    chk("R8 power-on clears cause", cause_o, 5'b00001);
    bmon_expire = 1'b1; cyc(2); bmon_expire = 1'b0; cyc(4);
    chk("R9 hard ignored in power-on", cause_o, 5'b00001);
    tap_isolate = 1'b0; por_req_n = 1'b1; cyc(50);
    chk("R10 all released", dom_v, 7'd0);
    chk("R3 cfg recaptured", cfg_latched_o, 8'h33);

    // R3: hard flow keeps configuration
    cfg_pins_i = 8'hC3;
    ext_pin_low = 1'b1; cyc(3); ext_pin_low = 1'b0; cyc(6);
    chk("R6 pin hard flow", dom_v, exp_dom(2));
    chk("R11 pin cause", cause_o, 5'b00010);
    cyc(50);
    chk("R3 cfg untouched by hard", cfg_latched_o, 8'h33);
    chk("R6 no self retrigger", dom_v, 7'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule